// File: doc/BRIEF.md
# Dual-Port Scratchpad with Halfword Instruction Fetch

The block is a small on-chip scratchpad RAM that two agents share. An instruction fetch port can only read. It takes any halfword-aligned byte address and, one cycle after the request is accepted, returns a 64-bit packet of four consecutive halfwords together with a count of how many of them are valid. The RAM is divided into lines of `LINE_HW` halfwords. A packet never crosses into the next line: if the four halfwords would run past the end of the current line, only the halfwords up to the line end are delivered, and the count reports how many there are.

A system bus slave port performs single-beat 32-bit reads and writes with per-byte enables. It is used to load the scratchpad and to inspect it. The storage is four interleaved halfword banks. Because of this, a fetch at any halfword offset reads its four halfwords in a single access, and a bus word maps onto one pair of banks.

A registered arbiter decides which port uses the banks in each cycle. It has four states:
- `ARB_IDLE`: nothing was granted in the previous cycle.
- `ARB_FETCH`: a fetch was granted.
- `ARB_BUS_RD`: a bus read was granted.
- `ARB_BUS_WR`: a bus write was granted.

The transitions follow the grant made in the current cycle:
- A bus grant moves to `ARB_BUS_WR` or `ARB_BUS_RD`, depending on the write flag.
- Otherwise, a fetch grant moves to `ARB_FETCH`.
- Otherwise, the arbiter returns to `ARB_IDLE`.

The bus has priority, with one exception: when the state is a bus state and a fetch is requesting, the fetch takes its turn. As a result, neither port ever waits more than one cycle.

Top module: `spf_scratchpad`

## Requirements
- R1: A fetch accepted on a clock edge (`fch_req` and `fch_ready` high) produces `fch_valid` for exactly one cycle, one clock later. When the halfword offset within the line is at most `LINE_HW`-4, `fch_count` is 4 and all four halfwords are returned.
- R2: When the halfword offset within the line is greater than `LINE_HW`-4, `fch_count` equals `LINE_HW` minus the offset (1 to 3). Only the halfwords up to the end of that line are returned, with no wrap and no second cycle.
- R3: Packet halfword k, held in `fch_data[16k+15:16k]`, holds the halfword at byte address 2*(hw+k), where hw is the fetch halfword index. Each halfword is little endian (the lower byte address goes to bits [7:0]). Halfwords at or above `fch_count` read as zero.
- R4: The fetch port has no write path. No number of fetches changes any RAM byte, as seen through bus reads.
- R5: A bus write with `bus_we`=1 that is accepted changes only the bytes whose `bus_be` bit is set. Bit i enables byte address (`bus_addr` & ~3)+i, taken from `bus_wdata[8i+7:8i]`. The write is acknowledged by `bus_ack` one cycle after acceptance.
- R6: A bus read that is accepted presents the 32-bit word at `bus_addr` & ~3 on `bus_rdata` in the following cycle, together with `bus_ack`. Byte address +i appears in bits [8i+7:8i].
- R7: When both ports request and no bus access was granted in the previous cycle, the bus is accepted (`bus_ready`=1) and the fetch is stalled (`fch_ready`=0).
- R8: When a bus access was granted in the previous cycle and a fetch is requesting, the fetch is accepted and `bus_ready` is 0. Under continuous requests from both ports, grants therefore alternate, and no request waits more than one cycle.
- R9: During and directly after reset, `fch_valid` and `bus_ack` are 0, and `fch_count`, `fch_data` and `bus_rdata` are 0. Whenever `fch_valid` is 0, `fch_count` and `fch_data` are 0.
- R10: Bit 0 of `fch_addr` is ignored. A fetch at an odd address returns the same packet as the even address below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fch_req | input | 1 | Fetch request |
| fch_addr | input | AW | Fetch byte address (halfword aligned) |
| fch_ready | output | 1 | Fetch accepted this cycle if requested |
| fch_valid | output | 1 | Fetch packet valid |
| fch_data | output | 64 | Four halfwords, lowest address in bits [15:0] |
| fch_count | output | 3 | Number of valid halfwords (1 to 4) |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Bus byte address (word aligned) |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Bus access accepted this cycle if requested |
| bus_ack | output | 1 | Bus access completed |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` after a read |

## Verification
The fetch path is exercised with every halfword offset of three different lines, including the topmost line of the RAM. This separates the full-packet case from each of the three truncated lengths, and exposes any lane rotation error across the four banks. Odd fetch addresses are repeated against their even neighbours. Byte-enable patterns that alternate bytes and touch only the top byte show whether write masking is per byte. A full readback after the fetch sweep shows that fetching never disturbs memory. Simultaneous requests are issued from idle, right after a bus grant and continuously over several cycles, which separates fixed bus priority from the one-cycle fetch turn.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;

    // number of halfword lanes in a fetch packet (and of RAM banks)
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_FETCH  = 2'd1,
        ARB_BUS_RD = 2'd2,
        ARB_BUS_WR = 2'd3
    } arb_state_t;

endpackage

// File: rtl/spf_bank.sv
`timescale 1ns/1ps
module spf_bank #(
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [1:0]    be,
    input  logic [RW-1:0] row,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata
);
    localparam int DEPTH = 1 << RW;

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                if (be[0]) mem[row][7:0]  <= wdata[7:0];
                if (be[1]) mem[row][15:8] <= wdata[15:8];
            end
            rdata <= mem[row];
        end
    end
endmodule

// File: rtl/spf_arbiter.sv
`timescale 1ns/1ps
module spf_arbiter
    import spf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fch_req,
    input  logic       bus_req,
    input  logic       bus_we,
    output logic       fch_ready,
    output logic       bus_ready,
    output logic       fch_grant,
    output logic       bus_grant,
    output arb_state_t state_q
);
    arb_state_t state_d;
    logic       bus_last;
    logic       fetch_turn;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // grants, readies and next state
    always_comb begin
        unique case (state_q)
            ARB_BUS_RD, ARB_BUS_WR: bus_last = 1'b1;
            ARB_IDLE, ARB_FETCH:    bus_last = 1'b0;
            default:                bus_last = 1'b0;
        endcase
        fetch_turn = bus_last && fch_req;
        bus_grant  = bus_req && !fetch_turn;
        fch_grant  = fch_req && !bus_grant;
        bus_ready  = !fetch_turn;
        fch_ready  = !bus_grant;
        if (bus_grant)      state_d = bus_we ? ARB_BUS_WR : ARB_BUS_RD;
        else if (fch_grant) state_d = ARB_FETCH;
        else                state_d = ARB_IDLE;
    end

    // R7
    bus_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && fch_req && (state_q == ARB_IDLE || state_q == ARB_FETCH))
        |-> (bus_ready && !fch_ready));

    // R8
    fetch_wait_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fch_req && !fch_ready) |=> (!fch_req || fch_ready));

    // R8
    bus_wait_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (!bus_req || bus_ready));
endmodule

// File: rtl/spf_fetch_align.sv
`timescale 1ns/1ps
module spf_fetch_align #(
    parameter int HWA     = 9,
    parameter int LINE_HW = 16
) (
    input  logic [HWA-1:0]       hw_addr,
    output logic [3:0][HWA-3:0]  bank_row,
    output logic [2:0]           count
);
    localparam int OW = $clog2(LINE_HW);

    // each bank supplies the lane whose halfword index maps onto it
    for (genvar b = 0; b < 4; b++) begin : g_row
        logic [1:0]     lane;
        logic [HWA-1:0] sum;
        assign lane        = 2'(b) - hw_addr[1:0];
        assign sum         = hw_addr + HWA'(lane);
        assign bank_row[b] = sum[HWA-1:2];
    end

    logic [OW:0] remain;
    always_comb begin
        remain = (OW+1)'(LINE_HW) - {1'b0, hw_addr[OW-1:0]};
        count  = (remain >= (OW+1)'(4)) ? 3'd4 : remain[2:0];
    end
endmodule

// File: rtl/spf_fetch_pack.sv
`timescale 1ns/1ps
module spf_fetch_pack (
    input  logic             valid,
    input  logic [1:0]       shift,
    input  logic [2:0]       count,
    input  logic [3:0][15:0] bank_q,
    output logic [63:0]      data
);
    for (genvar k = 0; k < 4; k++) begin : g_lane
        logic [1:0] src;
        assign src = shift + 2'(k);
        assign data[16*k +: 16] = (valid && (3'(k) < count)) ? bank_q[src] : 16'h0;
    end
endmodule

// File: rtl/spf_scratchpad.sv
`timescale 1ns/1ps
module spf_scratchpad
    import spf_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    parameter int LINE_HW   = 16,
    parameter int AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fch_req,
    input  logic [AW-1:0] fch_addr,
    output logic          fch_ready,
    output logic          fch_valid,
    output logic [63:0]   fch_data,
    output logic [2:0]    fch_count,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [3:0]    bus_be,
    input  logic [31:0]   bus_wdata,
    output logic          bus_ready,
    output logic          bus_ack,
    output logic [31:0]   bus_rdata
);
    localparam int HWA = AW - 1;
    localparam int RW  = AW - 3;
    localparam int OW  = $clog2(LINE_HW);

    arb_state_t state_q;
    logic       fch_grant, bus_grant;

    spf_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fch_req   (fch_req),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .fch_ready (fch_ready),
        .bus_ready (bus_ready),
        .fch_grant (fch_grant),
        .bus_grant (bus_grant),
        .state_q   (state_q)
    );

    logic [2:0] unused_addr_bits;
    assign unused_addr_bits = {fch_addr[0], bus_addr[1:0]};

    logic [3:0][RW-1:0] fch_row;
    logic [2:0]         count_d;

    spf_fetch_align #(.HWA(HWA), .LINE_HW(LINE_HW)) u_align (
        .hw_addr  (fch_addr[AW-1:1]),
        .bank_row (fch_row),
        .count    (count_d)
    );

    logic [RW-1:0]    bus_row;
    logic             bus_hi;
    logic [3:0][15:0] bank_q;

    assign bus_row = bus_addr[AW-1:3];
    assign bus_hi  = bus_addr[2];

    for (genvar b = 0; b < 4; b++) begin : g_bank
        logic          en, we;
        logic [1:0]    be;
        logic [15:0]   wd;
        logic [RW-1:0] row;

        always_comb begin
            en  = 1'b0;
            we  = 1'b0;
            be  = 2'b00;
            wd  = bus_wdata[16*(b%2) +: 16];
            row = fch_row[b];
            if (bus_grant) begin
                en  = ((b / 2) == 0) ? !bus_hi : bus_hi;
                we  = bus_we;
                be  = bus_be[2*(b%2) +: 2];
                row = bus_row;
            end else if (fch_grant) begin
                en  = 1'b1;
            end
        end

        spf_bank #(.RW(RW)) u_bank (
            .clk   (clk),
            .en    (en),
            .we    (we),
            .be    (be),
            .row   (row),
            .wdata (wd),
            .rdata (bank_q[b])
        );
    end

    logic [1:0] shift_q;
    logic [2:0] count_q;
    logic       bus_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= 2'd0;
            count_q  <= 3'd0;
            bus_hi_q <= 1'b0;
        end else begin
            if (fch_grant) begin
                shift_q <= fch_addr[2:1];
                count_q <= count_d;
            end
            if (bus_grant) bus_hi_q <= bus_hi;
        end
    end

    always_comb begin
        unique case (state_q)
            ARB_FETCH: begin
                fch_valid = 1'b1;
                bus_ack   = 1'b0;
                bus_rdata = 32'h0;
            end
            ARB_BUS_RD: begin
                fch_valid = 1'b0;
                bus_ack   = 1'b1;
                bus_rdata = bus_hi_q ? {bank_q[3], bank_q[2]} : {bank_q[1], bank_q[0]};
            end
            ARB_BUS_WR: begin
                fch_valid = 1'b0;
                bus_ack   = 1'b1;
                bus_rdata = 32'h0;
            end
            default: begin
                fch_valid = 1'b0;
                bus_ack   = 1'b0;
                bus_rdata = 32'h0;
            end
        endcase
        fch_count = fch_valid ? count_q : 3'd0;
    end

    spf_fetch_pack u_pack (
        .valid  (fch_valid),
        .shift  (shift_q),
        .count  (count_q),
        .bank_q (bank_q),
        .data   (fch_data)
    );

    // R1
    valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fch_valid |-> $past(fch_req && fch_ready));

    // R6
    ack_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req && bus_ready));

    // R2
    count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fch_valid |-> (int'(fch_count) ==
            (((LINE_HW - int'($past(fch_addr[OW:1]))) < 4) ?
             (LINE_HW - int'($past(fch_addr[OW:1]))) : 4)));

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fch_valid && fch_count < 3'd4) |-> (fch_data[63:48] == 16'h0));

    // R9
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fch_valid |-> (fch_count == 3'd0 && fch_data == 64'h0));
endmodule

// File: tb/sim_spf_scratchpad.sv
`timescale 1ns/1ps
module sim_spf_scratchpad;
    localparam int MEM_BYTES = 1024;
    localparam int AW        = 10;
    localparam int LINE_HW   = 16;

    logic          clk, rst_n;
    logic          fch_req, fch_ready, fch_valid;
    logic [AW-1:0] fch_addr;
    logic [63:0]   fch_data;
    logic [2:0]    fch_count;
    logic          bus_req, bus_we, bus_ready, bus_ack;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be;
    logic [31:0]   bus_wdata, bus_rdata;

    spf_scratchpad #(.MEM_BYTES(MEM_BYTES), .LINE_HW(LINE_HW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fch_req(fch_req), .fch_addr(fch_addr), .fch_ready(fch_ready),
        .fch_valid(fch_valid), .fch_data(fch_data), .fch_count(fch_count),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int           n_chk = 0;
    int           n_fail = 0;
    logic [7:0]   mdl [MEM_BYTES];
    bit           last_bus = 1'b0;
    logic [66:0]  fq[$];
    string        fq_tag[$];
    logic [32:0]  bq[$];
    string        bq_tag[$];

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [66:0] exp_fetch(input logic [AW-1:0] a);
        int hw, off, cnt, idx;
        logic [63:0] d;
        hw  = int'(a) >> 1;
        off = hw % LINE_HW;
        cnt = (LINE_HW - off >= 4) ? 4 : LINE_HW - off;
        d   = 64'h0;
        for (int k = 0; k < cnt; k++) begin
            idx = (2 * (hw + k)) % MEM_BYTES;
            d[16*k +: 16] = {mdl[idx+1], mdl[idx]};
        end
        return {3'(cnt), d};
    endfunction

    function automatic logic [31:0] mdl_word(input logic [AW-1:0] a);
        int b;
        b = int'(a) & ~3;
        return {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]};
    endfunction

    // one clock cycle of stimulus on both ports
    task automatic cyc(input bit fr, input logic [AW-1:0] fa,
                       input bit br, input bit bwe, input logic [AW-1:0] ba,
                       input logic [3:0] bbe, input logic [31:0] bwd,
                       input string tag, output bit f_acc, output bit b_acc);
        bit exp_br, exp_fr;
        int base;
        @(negedge clk);
        fch_req = fr; fch_addr = fa;
        bus_req = br; bus_we = bwe; bus_addr = ba; bus_be = bbe; bus_wdata = bwd;
        #1;
        exp_br = !(last_bus && fr);
        exp_fr = !(br && exp_br);
        if (fr) check(fch_ready == exp_fr, {tag, " R7/R8 fch_ready"}, 128'(fch_ready), 128'(exp_fr));
        if (br) check(bus_ready == exp_br, {tag, " R7/R8 bus_ready"}, 128'(bus_ready), 128'(exp_br));
        f_acc = fr && fch_ready;
        b_acc = br && bus_ready;
        if (f_acc) begin
            fq.push_back(exp_fetch(fa));
            fq_tag.push_back(tag);
        end
        if (b_acc) begin
            if (bwe) begin
                base = int'(ba) & ~3;
                for (int i = 0; i < 4; i++)
                    if (bbe[i]) mdl[base+i] = bwd[8*i +: 8];
                bq.push_back({1'b0, 32'h0});
            end else begin
                bq.push_back({1'b1, mdl_word(ba)});
            end
            bq_tag.push_back(tag);
        end
        @(posedge clk);
        last_bus = b_acc;
    endtask

    task automatic idle(input int n);
        bit fa, ba;
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, '0, 4'h0, 32'h0, "idle", fa, ba);
    endtask

    task automatic fetch(input logic [AW-1:0] a, input string tag);
        bit fa, ba;
        do cyc(1, a, 0, 0, '0, 4'h0, 32'h0, tag, fa, ba); while (!fa);
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [3:0] be,
                          input logic [31:0] d, input string tag);
        bit fa, ba;
        do cyc(0, '0, 1, 1, a, be, d, tag, fa, ba); while (!ba);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input string tag);
        bit fa, ba;
        do cyc(0, '0, 1, 0, a, 4'h0, 32'h0, tag, fa, ba); while (!ba);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (fch_valid) begin
                if (fq.size() == 0) begin
                    check(1'b0, "R1 unexpected fch_valid", 128'(fch_data), 128'(0));
                end else begin
                    logic [66:0] e;
                    string t;
                    e = fq.pop_front();
                    t = fq_tag.pop_front();
                    check({fch_count, fch_data} == e, {t, " R1/R2/R3 packet"},
                          128'({fch_count, fch_data}), 128'(e));
                end
            end
            if (bus_ack) begin
                if (bq.size() == 0) begin
                    check(1'b0, "R5/R6 unexpected bus_ack", 128'(bus_rdata), 128'(0));
                end else begin
                    logic [32:0] e;
                    string t;
                    e = bq.pop_front();
                    t = bq_tag.pop_front();
                    if (e[32]) check(bus_rdata == e[31:0], {t, " R6 read data"},
                                     128'(bus_rdata), 128'(e[31:0]));
                    else       check(1'b1, {t, " R5 write ack"}, 128'(1), 128'(1));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1 watchdog timeout", 128'(0), 128'(1));
        summary();
        $finish;
    end

    initial begin
        bit fa, ba;
        int nf, nb;
        rst_n = 1'b0;
        fch_req = 0; fch_addr = '0; bus_req = 0; bus_we = 0; bus_addr = '0;
        bus_be = 4'h0; bus_wdata = 32'h0;
        for (int i = 0; i < MEM_BYTES; i++) mdl[i] = 8'h00;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(fch_valid == 1'b0, "R9 fch_valid in reset", 128'(fch_valid), 128'(0));
        check(bus_ack == 1'b0, "R9 bus_ack in reset", 128'(bus_ack), 128'(0));
        check(fch_count == 3'd0 && fch_data == 64'h0, "R9 fetch outputs in reset",
              128'({fch_count, fch_data}), 128'(0));
        check(bus_rdata == 32'h0, "R9 bus_rdata in reset", 128'(bus_rdata), 128'(0));
        rst_n = 1'b1;
        idle(1);
        @(negedge clk);
        check(fch_valid == 1'b0 && bus_ack == 1'b0, "R9 outputs after reset",
              128'({fch_valid, bus_ack}), 128'(0));

        // R5: fill memory with full-word writes
        for (int w = 0; w < MEM_BYTES / 4; w++)
            bus_wr(AW'(w * 4), 4'hF, 32'h9E3779B9 * (w + 1) ^ 32'h5A5A0000, "R5 fill");

        // R6: word reads
        bus_rd(AW'(0), "R6 rd0");
        bus_rd(AW'(4), "R6 rd4");
        bus_rd(AW'(MEM_BYTES - 4), "R6 rdtop");

        // R5: byte enable masking
        bus_wr(AW'(40), 4'b0101, 32'hDEADBEEF, "R5 be0101");
        bus_wr(AW'(44), 4'b1000, 32'h12345678, "R5 be1000");
        bus_wr(AW'(48), 4'b0000, 32'hFFFFFFFF, "R5 be0000");
        bus_rd(AW'(40), "R5 rd40");
        bus_rd(AW'(44), "R5 rd44");
        bus_rd(AW'(48), "R5 rd48");

        // R1, R2, R3: every halfword offset in three lines, back to back
        for (int o = 0; o < LINE_HW; o++) fetch(AW'(2 * o), "R1/R2 line0");
        for (int o = 0; o < LINE_HW; o++) fetch(AW'(5 * 2 * LINE_HW + 2 * o), "R2/R3 line5");
        for (int o = 0; o < LINE_HW; o++)
            fetch(AW'(MEM_BYTES - 2 * LINE_HW + 2 * o), "R2 lastline");

        // R10: odd fetch addresses
        fetch(AW'(2 * 3 + 1), "R10 odd3");
        fetch(AW'(2 * 14 + 1), "R10 odd14");
        fetch(AW'(2 * 15 + 1), "R10 odd15");

        // R7: simultaneous requests from idle, bus wins
        idle(1);
        cyc(1, AW'(64), 1, 1, AW'(200), 4'hF, 32'hCAFEF00D, "R7 both", fa, ba);
        check(ba == 1'b1 && fa == 1'b0, "R7 bus first", 128'({ba, fa}), 128'(2'b10));
        // R8: fetch takes its turn right after
        cyc(1, AW'(64), 1, 0, AW'(200), 4'h0, 32'h0, "R8 turn", fa, ba);
        check(fa == 1'b1 && ba == 1'b0, "R8 fetch turn", 128'({ba, fa}), 128'(2'b01));
        bus_rd(AW'(200), "R8 rd200");

        // R8: continuous contention alternates grants
        nf = 0; nb = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(1, AW'(2 * i + 2), 1, (i % 2) == 0, AW'(300 + 4 * i), 4'hF,
                32'h0BADF00D + i, "R8 stream", fa, ba);
            nf += int'(fa); nb += int'(ba);
        end
        check(nf == 3 && nb == 3, "R8 alternation", 128'({nf[7:0], nb[7:0]}), 128'(16'h0303));

        // R4: full readback after all fetches
        for (int w = 0; w < MEM_BYTES / 4; w++) bus_rd(AW'(w * 4), "R4 readback");

        idle(3);
        check(fq.size() == 0, "R1 pending fetches", 128'(fq.size()), 128'(0));
        check(bq.size() == 0, "R6 pending bus", 128'(bq.size()), 128'(0));
        summary();
        $finish;
    end
endmodule